// File: doc/BRIEF.md
# EDO DRAM Access Controller

This block sits between a simple word-request port and an asynchronous EDO DRAM of 4M words by 16 bits. A request carries a 22-bit word address, 16-bit write data, two byte enables and a write flag. The controller splits the address into a 12-bit row (upper bits) and a 10-bit column (lower bits) and puts both on one shared 12-bit address bus. It sequences the row strobe, the two byte-lane column strobes, write enable and output enable. Every interval is a parameter counted in clock cycles.

A row stays open after an access. A later request to the same row needs only a new column strobe pulse, so the row strobe does not cycle. A request to another row closes the row, waits out precharge and opens the new row. Writes are always issued as early writes, so the memory never drives the data pins during a write. Read data is sampled one clock after the column strobe rises, which relies on the extended data-out hold of the memory.

Refresh and power-up sequencing are done by a neighbouring block. That block raises a hold request. The controller then closes its row, stops taking requests and reports the bus as granted once the row strobe is high.

Top module: `edo_ctrl`

## Requirements
- R1: After reset the row strobe, both column strobes, write enable and output enable are high, the data pins are not driven, ready_o is high and grant_o is low.
- R2: On the row strobe's falling edge the address bus holds addr_i[21:10]. On a column strobe's falling edge it holds {2'b00, addr_i[9:0]}. The first column strobe falls at least T_RCD cycles after the row strobe falls.
- R3: On a write, write enable is low and the write data is driven for at least one cycle before any column strobe falls, and output enable stays high. The data pins are never driven while output enable is low.
- R4: On a write, the lower column strobe (data bits 7:0) falls only if be_i[0] is 1, and the upper column strobe (bits 15:8) falls only if be_i[1] is 1. A write with be_i = 2'b00 pulses neither strobe and changes no memory. A read pulses both strobes.
- R5: A column strobe stays low T_CAS cycles. Read data is sampled one cycle after the strobe rises. It appears on rdata_o together with a single-cycle rvalid_o pulse.
- R6: A request to the currently open row is served without cycling the row strobe. Both column strobes stay high for at least T_CP cycles between pulses.
- R7: The row strobe stays low for at least T_RAS_MIN cycles and then stays high for at least T_RP cycles before a new row opens. A request to a different row is served after that precharge.
- R8: The row strobe is never low for more than PAGE_LIMIT cycles. A row left open without requests is closed before that limit.
- R9: While hold_i is high, ready_o is low and no request is accepted, including one presented in the same cycle that hold_i rises. The open row is closed, and grant_o is high only when the row strobe is high and precharge has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request valid |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 22 | Word address, row in upper 12 bits |
| wdata_i | input | 16 | Write data |
| be_i | input | 2 | Byte enables, bit 0 = low byte |
| ready_o | output | 1 | Request accepted when req_i and ready_o are both high at a clock edge |
| rdata_o | output | 16 | Read data |
| rvalid_o | output | 1 | rdata_o valid, one cycle |
| hold_i | input | 1 | Refresh block asks for the memory |
| grant_o | output | 1 | Memory idle and released to the refresh block |
| dram_addr_o | output | 12 | Multiplexed row/column address |
| dram_ras_no | output | 1 | Row strobe, active low |
| dram_lcas_no | output | 1 | Lower-byte column strobe, active low |
| dram_ucas_no | output | 1 | Upper-byte column strobe, active low |
| dram_we_no | output | 1 | Write enable, active low |
| dram_oe_no | output | 1 | Output enable, active low |
| dram_dq_o | output | 16 | Write data to the memory |
| dram_dq_oe_o | output | 1 | Drive enable for dram_dq_o |
| dram_dq_i | input | 16 | Read data from the memory |

## Verification
A hold request from the refresh block can arrive in the same cycle as a request to the open row. The bench raises hold_i and req_i at the same clock with a page-hit address. It then checks four things: ready_o is already low in that cycle, no column strobe pulses while hold_i stays high, the row strobe rises and grant_o follows. After hold_i drops, the still-pending request must be served with the correct data. The page-limit close is also provoked. A row is left idle well past PAGE_LIMIT, and every row-strobe low period is measured against both bounds.

// File: rtl/edo_ctrl_pkg.sv
package edo_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_CAS,
    ST_CP,
    ST_OPEN,
    ST_CLOSE,
    ST_PRE
  } edo_state_e;

  function automatic int unsigned edo_max(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/edo_ctrl_timer.sv
module edo_ctrl_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= load_val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/edo_ctrl_rowtrk.sv
module edo_ctrl_rowtrk #(
  parameter int unsigned ROW_W      = 12,
  parameter int unsigned T_RAS_MIN  = 13,
  parameter int unsigned PAGE_LIMIT = 24000,
  parameter int unsigned GUARD      = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ras_low_i,
  input  logic             open_i,
  input  logic [ROW_W-1:0] open_row_i,
  input  logic [ROW_W-1:0] req_row_i,
  output logic             hit_o,
  output logic             ras_min_ok_o,
  output logic             expire_o
);
  localparam int unsigned RC_W = $clog2(PAGE_LIMIT + 1);

  logic [RC_W-1:0]  ras_cnt_q;
  logic [ROW_W-1:0] row_q;
  logic             row_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            ras_cnt_q <= '0;
    else if (!ras_low_i)                    ras_cnt_q <= '0;
    else if (ras_cnt_q != RC_W'(PAGE_LIMIT)) ras_cnt_q <= ras_cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q     <= '0;
      row_vld_q <= 1'b0;
    end else if (open_i) begin
      row_q     <= open_row_i;
      row_vld_q <= 1'b1;
    end else if (!ras_low_i) begin
      row_vld_q <= 1'b0;
    end
  end

  assign hit_o        = row_vld_q && (row_q == req_row_i);
  assign ras_min_ok_o = ras_cnt_q >= RC_W'(T_RAS_MIN - 1);
  assign expire_o     = ras_cnt_q >= RC_W'(PAGE_LIMIT - GUARD);

  assert_ras_min_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_low_i) |-> $past(ras_cnt_q) >= RC_W'(T_RAS_MIN - 1));

  assert_page_limit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ras_low_i |-> ras_cnt_q < RC_W'(PAGE_LIMIT));
endmodule

// File: rtl/edo_ctrl_rdcap.sv
module edo_ctrl_rdcap #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= capture_i;
      if (capture_i) rdata_o <= dq_i;
    end
  end

  assert_rvalid_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);
endmodule

// File: rtl/edo_ctrl.sv
module edo_ctrl
  import edo_ctrl_pkg::*;
#(
  parameter int unsigned ROW_W      = 12,
  parameter int unsigned COL_W      = 10,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned T_RCD      = 3,
  parameter int unsigned T_CAS      = 5,
  parameter int unsigned T_CP       = 2,
  parameter int unsigned T_RP       = 8,
  parameter int unsigned T_RAS_MIN  = 13,
  parameter int unsigned PAGE_LIMIT = 24000
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic                     we_i,
  input  logic [ROW_W+COL_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic [DATA_W/8-1:0]      be_i,
  output logic                     ready_o,
  output logic [DATA_W-1:0]        rdata_o,
  output logic                     rvalid_o,
  input  logic                     hold_i,
  output logic                     grant_o,
  output logic [ROW_W-1:0]         dram_addr_o,
  output logic                     dram_ras_no,
  output logic                     dram_lcas_no,
  output logic                     dram_ucas_no,
  output logic                     dram_we_no,
  output logic                     dram_oe_no,
  output logic [DATA_W-1:0]        dram_dq_o,
  output logic                     dram_dq_oe_o,
  input  logic [DATA_W-1:0]        dram_dq_i
);
  localparam int unsigned ADDR_W = ROW_W + COL_W;
  localparam int unsigned LANES  = DATA_W / 8;
  localparam int unsigned GUARD  = T_CAS + T_CP + 4;
  localparam int unsigned TMR_W  = $clog2(edo_max(edo_max(T_RCD, T_CAS), edo_max(T_CP, T_RP)) + 1);
  localparam logic [TMR_W-1:0] ROW_LD = TMR_W'(T_RCD - 2);
  localparam logic [TMR_W-1:0] CAS_LD = TMR_W'(T_CAS - 1);
  localparam logic [TMR_W-1:0] CP_LD  = TMR_W'(T_CP - 1);
  localparam logic [TMR_W-1:0] RP_LD  = TMR_W'(T_RP - 1);
  localparam int unsigned CPC_W  = $clog2(T_CP + 2);

  edo_state_e state_q, state_d;
  logic              pend_q, pend_d;
  logic [ADDR_W-1:0] lat_addr_q;
  logic [DATA_W-1:0] lat_wdata_q;
  logic [LANES-1:0]  lat_be_q;
  logic              lat_we_q;
  logic              acc;
  logic              tmr_load, tmr_zero;
  logic [TMR_W-1:0]  tmr_val, tmr_cnt;
  logic              hit, ras_min_ok, expire;
  logic              ras_low, cas_act, capture;
  logic [LANES-1:0]  lane_cas;

  assign ras_low = state_q inside {ST_ROW, ST_COL, ST_CAS, ST_CP, ST_OPEN, ST_CLOSE};
  assign cas_act = (state_q == ST_CAS);

  assign ready_o = !hold_i &&
                   (((state_q == ST_IDLE) && !pend_q) || ((state_q == ST_OPEN) && !expire));
  assign acc     = req_i && ready_o;
  assign grant_o = hold_i && (state_q == ST_IDLE);

  always_comb begin
    state_d  = state_q;
    pend_d   = pend_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: if (!hold_i && (pend_q || acc)) begin
        state_d = ST_ROW; tmr_load = 1'b1; tmr_val = ROW_LD;
      end
      ST_ROW: if (tmr_zero) state_d = ST_COL;
      ST_COL: begin
        state_d = ST_CAS; tmr_load = 1'b1; tmr_val = CAS_LD;
      end
      ST_CAS: if (tmr_zero) begin
        state_d = ST_CP; tmr_load = 1'b1; tmr_val = CP_LD;
      end
      ST_CP: if (tmr_zero) state_d = ST_OPEN;
      ST_OPEN: begin
        if (acc) begin
          if (hit) state_d = ST_COL;
          else begin
            pend_d  = 1'b1;
            state_d = ST_CLOSE;
          end
        end else if (hold_i || expire) begin
          state_d = ST_CLOSE;
        end
      end
      ST_CLOSE: if (ras_min_ok) begin
        state_d = ST_PRE; tmr_load = 1'b1; tmr_val = RP_LD;
      end
      ST_PRE: if (tmr_zero) begin
        if (pend_q && !hold_i) begin
          state_d = ST_ROW; tmr_load = 1'b1; tmr_val = ROW_LD;
        end else begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (state_d == ST_ROW && state_q != ST_ROW) pend_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_addr_q  <= '0;
      lat_wdata_q <= '0;
      lat_be_q    <= '0;
      lat_we_q    <= 1'b0;
    end else if (acc) begin
      lat_addr_q  <= addr_i;
      lat_wdata_q <= wdata_i;
      lat_be_q    <= be_i;
      lat_we_q    <= we_i;
    end
  end

  edo_ctrl_timer #(.CNT_W(TMR_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .cnt_o      (tmr_cnt),
    .zero_o     (tmr_zero)
  );

  edo_ctrl_rowtrk #(
    .ROW_W      (ROW_W),
    .T_RAS_MIN  (T_RAS_MIN),
    .PAGE_LIMIT (PAGE_LIMIT),
    .GUARD      (GUARD)
  ) u_rowtrk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ras_low_i    (ras_low),
    .open_i       (state_q == ST_ROW),
    .open_row_i   (lat_addr_q[ADDR_W-1:COL_W]),
    .req_row_i    (addr_i[ADDR_W-1:COL_W]),
    .hit_o        (hit),
    .ras_min_ok_o (ras_min_ok),
    .expire_o     (expire)
  );

  // sample one cycle after the strobe rises: EDO keeps data valid
  assign capture = (state_q == ST_CP) && !lat_we_q && (tmr_cnt == CP_LD);

  edo_ctrl_rdcap #(.DATA_W(DATA_W)) u_rdcap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture),
    .dq_i      (dram_dq_i),
    .rdata_o   (rdata_o),
    .rvalid_o  (rvalid_o)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_cas[g] = cas_act && (!lat_we_q || lat_be_q[g]);
  end

  assign dram_ras_no  = !ras_low;
  assign dram_lcas_no = !lane_cas[0];
  assign dram_ucas_no = !lane_cas[LANES-1];
  assign dram_we_no   = !(lat_we_q && (state_q inside {ST_COL, ST_CAS}));
  assign dram_oe_no   = !(!lat_we_q && (state_q inside {ST_CAS, ST_CP}));
  assign dram_dq_oe_o = lat_we_q && (state_q inside {ST_COL, ST_CAS});
  assign dram_dq_o    = lat_wdata_q;
  assign dram_addr_o  = (state_q inside {ST_COL, ST_CAS, ST_CP})
                        ? {{(ROW_W-COL_W){1'b0}}, lat_addr_q[COL_W-1:0]}
                        : lat_addr_q[ADDR_W-1:COL_W];

  // precharge run of both column strobes, checked on every fall
  logic             cas_all_high;
  logic [CPC_W-1:0] cas_hi_cnt_q;
  assign cas_all_high = dram_lcas_no && dram_ucas_no;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               cas_hi_cnt_q <= '1;
    else if (!cas_all_high)                    cas_hi_cnt_q <= '0;
    else if (cas_hi_cnt_q != '1)               cas_hi_cnt_q <= cas_hi_cnt_q + 1'b1;
  end

  assert_cp_min_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_all_high) |-> $past(cas_hi_cnt_q) >= CPC_W'(T_CP - 1));

  assert_early_we_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($fell(dram_lcas_no) || $fell(dram_ucas_no)) && !dram_we_no) |-> $past(!dram_we_no));

  assert_bus_turn_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dram_oe_no |-> !dram_dq_oe_o);

  assert_grant_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> (dram_ras_no && $past(dram_ras_no)));
endmodule

// File: tb/edo_ctrl_bench.sv
module edo_ctrl_bench;
  localparam int T_RCD = 3, T_CAS = 5, T_CP = 2, T_RP = 8, T_RAS_MIN = 13;
  localparam int PAGE_LIMIT = 600;
  localparam int AA_CYC = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req = 0, we = 0, hold = 0;
  logic [21:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  be = '0;
  logic        ready, rvalid, grant;
  logic [15:0] rdata;
  logic [11:0] d_addr;
  logic        ras_n, lcas_n, ucas_n, we_n, oe_n, dq_oe;
  logic [15:0] dq_o, dq_i;

  edo_ctrl #(.PAGE_LIMIT(PAGE_LIMIT)) u_edo_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .be_i(be), .ready_o(ready), .rdata_o(rdata), .rvalid_o(rvalid),
    .hold_i(hold), .grant_o(grant), .dram_addr_o(d_addr), .dram_ras_no(ras_n),
    .dram_lcas_no(lcas_n), .dram_ucas_no(ucas_n), .dram_we_no(we_n), .dram_oe_no(oe_n),
    .dram_dq_o(dq_o), .dram_dq_oe_o(dq_oe), .dram_dq_i(dq_i)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory responder and pin monitor
  logic [15:0] mem [int unsigned];
  logic [11:0] rsp_row = '0, last_row = '0;
  logic [9:0]  last_col = '0;
  logic [1:0]  last_lanes = '0;
  logic [15:0] rd_data = '0;
  int rd_age = 0;
  bit rd_on = 0;
  logic p_ras = 1, p_l = 1, p_u = 1, p_we = 1;
  int ras_hi_run = 1000, ras_lo_run = 0, cas_hi_run = 1000, since_ras = 0;
  int ras_falls = 0, ras_rises = 0, cas_falls = 0;

  assign dq_i = (!oe_n && rd_on && rd_age >= AA_CYC) ? rd_data : 16'hBAD0;

  always @(negedge clk) if (rst_n) begin
    int unsigned key;
    logic [15:0] cur;
    if (p_ras && !ras_n) begin
      chk(ras_hi_run >= T_RP, "R7 precharge", ras_hi_run, T_RP);
      rsp_row = d_addr; last_row = d_addr; ras_falls++; since_ras = 0;
    end else if (!ras_n) since_ras++;
    if (!p_ras && ras_n) begin
      chk(ras_lo_run >= T_RAS_MIN, "R7 ras low min", ras_lo_run, T_RAS_MIN);
      chk(ras_lo_run <= PAGE_LIMIT, "R8 ras low max", ras_lo_run, PAGE_LIMIT);
      rd_on = 0; ras_rises++;
    end
    if ((p_l && !lcas_n) || (p_u && !ucas_n)) begin
      chk(since_ras >= T_RCD, "R2 ras to cas", since_ras, T_RCD);
      chk(cas_hi_run >= T_CP, "R6 cas precharge", cas_hi_run, T_CP);
      last_col = d_addr[9:0]; last_lanes = {!ucas_n, !lcas_n}; cas_falls++;
      key = {rsp_row, d_addr[9:0]};
      cur = mem.exists(key) ? mem[key] : 16'h0000;
      if (!we_n) begin
        chk(!p_we, "R3 we before cas", p_we, 0);
        chk(dq_oe && oe_n, "R3 data driven oe high", {dq_oe, oe_n}, 2'b11);
        if (!lcas_n) cur[7:0] = dq_o[7:0];
        if (!ucas_n) cur[15:8] = dq_o[15:8];
        mem[key] = cur;
        rd_on = 0;
      end else begin
        rd_data = cur; rd_on = 1; rd_age = 1;
      end
    end else if (rd_on) rd_age++;
    if (!oe_n && dq_oe) chk(0, "R3 bus contention", dq_oe, 0);
    ras_lo_run = ras_n ? 0 : ras_lo_run + 1;
    ras_hi_run = ras_n ? ras_hi_run + 1 : 0;
    cas_hi_run = (lcas_n && ucas_n) ? cas_hi_run + 1 : 0;
    p_ras = ras_n; p_l = lcas_n; p_u = ucas_n; p_we = we_n;
  end

  task automatic wait_ready();
    int n = 0;
    while (!ready && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic issue(bit w, logic [21:0] a, logic [15:0] d, logic [1:0] b);
    @(negedge clk);
    req = 1; we = w; addr = a; wdata = d; be = b;
    wait_ready();
    @(posedge clk);
    @(negedge clk);
    req = 0;
  endtask

  task automatic wr(logic [21:0] a, logic [15:0] d, logic [1:0] b);
    issue(1, a, d, b);
    wait_ready();
  endtask

  task automatic rd(logic [21:0] a, output logic [15:0] d);
    int n = 0;
    issue(0, a, 16'h0, 2'b11);
    while (!rvalid && n < 100) begin @(negedge clk); n++; end
    d = rvalid ? rdata : 16'hxxxx;
    @(negedge clk);
    chk(!rvalid, "R5 rvalid one cycle", rvalid, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk({ras_n, lcas_n, ucas_n, we_n, oe_n} == 5'b11111, "R1 strobes idle",
        {ras_n, lcas_n, ucas_n, we_n, oe_n}, 5'b11111);
    chk(!dq_oe, "R1 data not driven", dq_oe, 0);
    chk(ready && !grant, "R1 ready no grant", {ready, grant}, 2'b10);
  endtask

  task automatic t_basic();
    logic [15:0] d;
    wr({12'hABC, 10'h155}, 16'hC0DE, 2'b11);
    chk(last_row == 12'hABC, "R2 row address", last_row, 12'hABC);
    chk(last_col == 10'h155, "R2 column address", last_col, 10'h155);
    rd({12'hABC, 10'h155}, d);
    chk(d == 16'hC0DE, "R5 read data", d, 16'hC0DE);
    wr({12'hFFF, 10'h3FF}, 16'h5AA5, 2'b11);
    chk(last_row == 12'hFFF && last_col == 10'h3FF, "R2 top corner", {last_row, last_col}, 22'h3FFFFF);
    wr({12'h000, 10'h000}, 16'h1111, 2'b11);
    rd({12'hFFF, 10'h3FF}, d);
    chk(d == 16'h5AA5, "R5 top corner read", d, 16'h5AA5);
  endtask

  task automatic t_lanes();
    logic [15:0] d;
    int c;
    wr({12'h123, 10'h044}, 16'h1234, 2'b11);
    wr({12'h123, 10'h044}, 16'h00AB, 2'b01);
    chk(last_lanes == 2'b01, "R4 lower lane only", last_lanes, 2'b01);
    wr({12'h123, 10'h044}, 16'hCD00, 2'b10);
    chk(last_lanes == 2'b10, "R4 upper lane only", last_lanes, 2'b10);
    c = cas_falls;
    wr({12'h123, 10'h044}, 16'hFFFF, 2'b00);
    chk(cas_falls == c, "R4 no lane on be 00", cas_falls, c);
    rd({12'h123, 10'h044}, d);
    chk(last_lanes == 2'b11, "R4 read both lanes", last_lanes, 2'b11);
    chk(d == 16'hCDAB, "R4 merged bytes", d, 16'hCDAB);
  endtask

  task automatic t_hit();
    logic [15:0] d;
    int r;
    wr({12'h2B0, 10'h001}, 16'hAAAA, 2'b11);
    r = ras_falls;
    wr({12'h2B0, 10'h002}, 16'hBBBB, 2'b11);
    rd({12'h2B0, 10'h001}, d);
    chk(ras_falls == r, "R6 no row cycle on hit", ras_falls, r);
    chk(d == 16'hAAAA, "R6 hit read data", d, 16'hAAAA);
  endtask

  task automatic t_miss();
    logic [15:0] d;
    int r, q;
    r = ras_falls; q = ras_rises;
    rd({12'h2B1, 10'h001}, d);
    chk(ras_falls == r + 1 && ras_rises == q + 1, "R7 miss reopens row", ras_falls - r, 1);
    chk(last_row == 12'h2B1, "R7 new row", last_row, 12'h2B1);
    rd({12'h2B0, 10'h002}, d);
    chk(d == 16'hBBBB, "R7 data after miss", d, 16'hBBBB);
  endtask

  task automatic t_collide();
    logic [15:0] d;
    int c, n = 0;
    wr({12'h3C3, 10'h010}, 16'h7E57, 2'b11);
    c = cas_falls;
    @(negedge clk);
    hold = 1; req = 1; we = 0; addr = {12'h3C3, 10'h010}; be = 2'b11;
    #0;
    @(negedge clk);
    chk(!ready, "R9 ready low with hold", ready, 0);
    while (!grant && n < 200) begin @(negedge clk); n++; end
    chk(grant && ras_n, "R9 grant with row closed", {grant, ras_n}, 2'b11);
    repeat (5) @(negedge clk);
    chk(cas_falls == c && !ready, "R9 nothing served under hold", cas_falls - c, 0);
    hold = 0;
    @(negedge clk);
    wait_ready();
    @(posedge clk);
    @(negedge clk);
    req = 0;
    n = 0;
    while (!rvalid && n < 100) begin @(negedge clk); n++; end
    d = rdata;
    chk(rvalid && d == 16'h7E57, "R9 served after release", d, 16'h7E57);
  endtask

  task automatic t_expire();
    int q;
    logic [15:0] d;
    rd({12'h0F0, 10'h00F}, d);
    q = ras_rises;
    repeat (PAGE_LIMIT + 40) @(negedge clk);
    chk(ras_n && ras_rises == q + 1, "R8 idle row closed", {ras_n, ras_rises - q}, 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_basic();
    t_lanes();
    t_hit();
    t_miss();
    t_collide();
    t_expire();
    repeat (10) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule